// File: doc/BRIEF.md
# Speculative Load Ordering Guard

This block lets a load issue to the data cache ahead of an older memory access that has not yet finished, while keeping the result indistinguishable from strictly in-order execution. Each load that issues early takes a slot in a small tracking table. The slot records the cache line the load read, the tag of the older access it is waiting behind, and the load's own tag.

While the slot is held, every coherence invalidation is compared against the recorded line. A match marks the slot as tainted. When the older access reports completion with its tag, every slot waiting on that tag is resolved. A clean slot commits the early value. A tainted slot asks for the load to be squashed and replayed, and it reports the load's tag.

Stores are never admitted early. When every slot is taken, further loads are refused and must issue in program order. The flush itself, the cache and the coherence protocol lie outside the block.

Top module: `spec_load_guard`

## Requirements
- R1: After synchronous reset, no slot is held: `table_full`, `commit_mask`, `squash_mask` and `replay_req` are all 0, and a load request is granted into slot 0.
- R2: A load request (`req_is_store`=0) is granted combinationally in the same cycle whenever a slot is free. It takes the free slot with the lowest index, which `req_slot` reports.
- R3: A request with `req_is_store`=1 is never granted, even when slots are free.
- R4: When all 4 slots are held, `table_full` is 1 and no request is granted.
- R5: Lines are 64 bytes. The line address is the address with bits 5:0 dropped. An invalidation whose line address equals that of a held slot taints that slot, whatever the low 6 bits of either address are.
- R6: A completion tag sampled at a clock edge resolves every held slot whose recorded older-access tag equals it. An untainted slot then shows its bit set in `commit_mask` for exactly the following cycle.
- R7: A tainted slot resolved by a completion shows its bit in `squash_mask` (never together with `commit_mask`) for the following cycle. In that cycle `replay_req` is 1 and the slot's field of `res_load_tags` (slot s at bits s*6 +: 6) holds the load tag.
- R8: An invalidation that matches a slot in the same cycle as that slot's completion causes a squash, not a commit.
- R9: A resolved slot is freed at the same edge and can be granted again. Slots waiting on other tags are not affected, and a repeated completion tag then resolves nothing.
- R10: An invalidation of the same line in the same cycle as a granted request leaves the new slot tainted.
- R11: An invalidation of a different line has no effect on a held slot, which later commits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request to issue an access early |
| req_is_store | input | 1 | Request is a store (never admitted) |
| req_addr | input | 32 | Byte address read by the load |
| req_dep_tag | input | 4 | Tag of the older access being bypassed |
| req_load_tag | input | 6 | Tag of the load itself |
| req_grant | output | 1 | Request admitted into a slot this cycle |
| req_slot | output | 2 | Index of the slot taken |
| table_full | output | 1 | All slots held |
| inv_valid | input | 1 | Coherence invalidation present |
| inv_addr | input | 32 | Byte address of the invalidated line |
| cpl_valid | input | 1 | An older access completed |
| cpl_tag | input | 4 | Tag of the completed access |
| commit_mask | output | 4 | Per-slot commit, one cycle after completion |
| squash_mask | output | 4 | Per-slot squash, one cycle after completion |
| res_load_tags | output | 24 | Load tags of the resolved slots |
| replay_req | output | 1 | At least one load must be squashed and replayed |

## Verification
The bench builds the block with its default parameters: 4 slots, 64-byte lines, 4-bit dependency tags and 6-bit load tags. With these values, four loads fill the table, so the full-table refusal and slot reuse can be reached in a few cycles. Offsets inside a 64-byte line, and the adjacent line, can be chosen directly to separate matching from non-matching invalidations. Same-cycle collisions between invalidation and completion, and between invalidation and a new grant, are driven explicitly.

// File: rtl/spec_guard_pkg.sv
package spec_guard_pkg;
    parameter int ADDR_W    = 32;
    parameter int LINE_OFS  = 6;
    parameter int SLOTS     = 4;
    parameter int DEP_W     = 4;
    parameter int LTAG_W    = 6;
    localparam int LINE_W   = ADDR_W - LINE_OFS;
    localparam int SLOT_W   = (SLOTS > 1) ? $clog2(SLOTS) : 1;

    typedef logic [LINE_W-1:0] line_t;
    typedef logic [DEP_W-1:0]  dep_t;
    typedef logic [LTAG_W-1:0] ltag_t;

    typedef struct packed {
        logic  held;
        logic  tainted;
        line_t line;
        dep_t  dep;
        ltag_t ltag;
    } slot_t;

    function automatic line_t line_of(input logic [ADDR_W-1:0] a);
        return a[ADDR_W-1:LINE_OFS];
    endfunction
endpackage

// File: rtl/spec_guard_pick.sv
module spec_guard_pick
    import spec_guard_pkg::*;
(
    input  logic [SLOTS-1:0]  busy,
    output logic [SLOTS-1:0]  free_onehot,
    output logic [SLOT_W-1:0] free_idx,
    output logic              all_busy
);
    always_comb begin
        free_idx = '0;
        for (int i = SLOTS - 1; i >= 0; i--) begin
            if (!busy[i]) free_idx = SLOT_W'(i);
        end
        all_busy    = &busy;
        free_onehot = all_busy ? '0 : (SLOTS'(1) << free_idx);
    end
endmodule

// File: rtl/spec_guard_slot.sv
module spec_guard_slot
    import spec_guard_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  set_i,
    input  line_t set_line,
    input  dep_t  set_dep,
    input  ltag_t set_ltag,
    input  logic  set_taint,
    input  logic  inv_valid,
    input  line_t inv_line,
    input  logic  cpl_valid,
    input  dep_t  cpl_tag,
    output logic  busy_o,
    output logic  commit_o,
    output logic  squash_o,
    output ltag_t ltag_o
);
    slot_t s;
    logic  inv_hit, resolve, bad;

    assign inv_hit  = inv_valid & s.held & (s.line == inv_line);
    assign resolve  = cpl_valid & s.held & (s.dep == cpl_tag);
    assign bad      = s.tainted | inv_hit;
    assign commit_o = resolve & ~bad;
    assign squash_o = resolve & bad;
    assign busy_o   = s.held;
    assign ltag_o   = s.ltag;

    always_ff @(posedge clk) begin
        if (rst) begin
            s <= '0;
        end else if (resolve) begin
            s.held    <= 1'b0;
            s.tainted <= 1'b0;
        end else if (set_i) begin
            s.held    <= 1'b1;
            s.tainted <= set_taint;
            s.line    <= set_line;
            s.dep     <= set_dep;
            s.ltag    <= set_ltag;
        end else if (inv_hit) begin
            s.tainted <= 1'b1;
        end
    end

    assert_taint_blocks_commit_R5: assert property (@(posedge clk) disable iff (rst)
        (inv_valid && busy_o && s.line == inv_line && !cpl_valid) |=> !commit_o);
    assert_freed_after_resolve_R9: assert property (@(posedge clk) disable iff (rst)
        (commit_o || squash_o) |=> !busy_o);
    assert_no_set_when_busy_R2: assert property (@(posedge clk) disable iff (rst)
        set_i |-> !busy_o);
    assert_same_cycle_squash_R8: assert property (@(posedge clk) disable iff (rst)
        (inv_valid && cpl_valid && busy_o && s.line == inv_line && s.dep == cpl_tag)
        |-> (squash_o && !commit_o));
endmodule

// File: rtl/spec_load_guard.sv
module spec_load_guard
    import spec_guard_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    req_valid,
    input  logic                    req_is_store,
    input  logic [ADDR_W-1:0]       req_addr,
    input  logic [DEP_W-1:0]        req_dep_tag,
    input  logic [LTAG_W-1:0]       req_load_tag,
    output logic                    req_grant,
    output logic [SLOT_W-1:0]       req_slot,
    output logic                    table_full,
    input  logic                    inv_valid,
    input  logic [ADDR_W-1:0]       inv_addr,
    input  logic                    cpl_valid,
    input  logic [DEP_W-1:0]        cpl_tag,
    output logic [SLOTS-1:0]        commit_mask,
    output logic [SLOTS-1:0]        squash_mask,
    output logic [SLOTS*LTAG_W-1:0] res_load_tags,
    output logic                    replay_req
);
    logic [SLOTS-1:0]        busy, pick_oh, set_vec, cmt_now, sqh_now;
    logic [SLOTS*LTAG_W-1:0] ltags_now;
    line_t                   req_line, inv_line;
    logic                    born_tainted;

    assign req_line     = line_of(req_addr);
    assign inv_line     = line_of(inv_addr);
    assign born_tainted = inv_valid & (inv_line == req_line);

    spec_guard_pick u_pick (
        .busy        (busy),
        .free_onehot (pick_oh),
        .free_idx    (req_slot),
        .all_busy    (table_full)
    );

    assign req_grant = req_valid & ~req_is_store & ~table_full;
    assign set_vec   = req_grant ? pick_oh : '0;

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        spec_guard_slot u_slot (
            .clk       (clk),
            .rst       (rst),
            .set_i     (set_vec[g]),
            .set_line  (req_line),
            .set_dep   (req_dep_tag),
            .set_ltag  (req_load_tag),
            .set_taint (born_tainted),
            .inv_valid (inv_valid),
            .inv_line  (inv_line),
            .cpl_valid (cpl_valid),
            .cpl_tag   (cpl_tag),
            .busy_o    (busy[g]),
            .commit_o  (cmt_now[g]),
            .squash_o  (sqh_now[g]),
            .ltag_o    (ltags_now[g*LTAG_W +: LTAG_W])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            commit_mask   <= '0;
            squash_mask   <= '0;
            res_load_tags <= '0;
            replay_req    <= 1'b0;
        end else begin
            commit_mask   <= cmt_now;
            squash_mask   <= sqh_now;
            res_load_tags <= ltags_now;
            replay_req    <= |sqh_now;
        end
    end

    assert_store_blocked_R3: assert property (@(posedge clk) disable iff (rst)
        req_is_store |-> !req_grant);
    assert_full_blocks_R4: assert property (@(posedge clk) disable iff (rst)
        table_full |-> !req_grant);
    assert_exclusive_result_R7: assert property (@(posedge clk) disable iff (rst)
        (commit_mask & squash_mask) == '0);
    assert_replay_follows_squash_R7: assert property (@(posedge clk) disable iff (rst)
        (|sqh_now) |=> replay_req);
    assert_one_grant_R2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(set_vec));
endmodule

// File: tb/tb_spec_load_guard.sv
module tb_spec_load_guard;
    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid, req_is_store;
    logic [31:0] req_addr;
    logic [3:0]  req_dep_tag;
    logic [5:0]  req_load_tag;
    logic        req_grant;
    logic [1:0]  req_slot;
    logic        table_full;
    logic        inv_valid;
    logic [31:0] inv_addr;
    logic        cpl_valid;
    logic [3:0]  cpl_tag;
    logic [3:0]  commit_mask, squash_mask;
    logic [23:0] res_load_tags;
    logic        replay_req;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    spec_load_guard dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_is_store(req_is_store), .req_addr(req_addr),
        .req_dep_tag(req_dep_tag), .req_load_tag(req_load_tag),
        .req_grant(req_grant), .req_slot(req_slot), .table_full(table_full),
        .inv_valid(inv_valid), .inv_addr(inv_addr),
        .cpl_valid(cpl_valid), .cpl_tag(cpl_tag),
        .commit_mask(commit_mask), .squash_mask(squash_mask),
        .res_load_tags(res_load_tags), .replay_req(replay_req)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        req_valid = 0; req_is_store = 0; req_addr = '0; req_dep_tag = '0; req_load_tag = '0;
        inv_valid = 0; inv_addr = '0; cpl_valid = 0; cpl_tag = '0;
    endtask

    // inputs held from one falling edge to the next; registered results then readable
    task automatic tick();
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic put_req(input logic [31:0] a, input logic [3:0] d, input logic [5:0] lt,
                           input logic st, input logic exp_g, input logic [1:0] exp_s,
                           input string req);
        req_valid = 1; req_is_store = st; req_addr = a; req_dep_tag = d; req_load_tag = lt;
        #1;
        chk(req, {31'd0, req_grant}, {31'd0, exp_g});
        if (exp_g) chk(req, {30'd0, req_slot}, {30'd0, exp_s});
    endtask

    task automatic alloc(input logic [31:0] a, input logic [3:0] d, input logic [5:0] lt,
                         input logic [1:0] exp_s, input string req);
        put_req(a, d, lt, 1'b0, 1'b1, exp_s, req);
        tick();
    endtask

    task automatic complete(input logic [3:0] t, input logic [3:0] exp_c,
                            input logic [3:0] exp_q, input string req);
        cpl_valid = 1; cpl_tag = t;
        tick();
        chk(req, {28'd0, commit_mask}, {28'd0, exp_c});
        chk(req, {28'd0, squash_mask}, {28'd0, exp_q});
        chk(req, {31'd0, replay_req}, {31'd0, (exp_q != 0)});
    endtask

    task automatic t_reset();
        rst = 1; idle_inputs();
        repeat (3) @(negedge clk);
        rst = 0;
        chk("R1 full", {31'd0, table_full}, 0);
        chk("R1 commit", {28'd0, commit_mask}, 0);
        chk("R1 squash", {28'd0, squash_mask}, 0);
        chk("R1 replay", {31'd0, replay_req}, 0);
        put_req(32'h100, 4'd0, 6'd0, 1'b0, 1'b1, 2'd0, "R1 first grant");
        idle_inputs();
        #1;
    endtask

    task automatic t_commit();
        alloc(32'h1000, 4'd1, 6'd5, 2'd0, "R2 alloc");
        complete(4'd1, 4'b0001, 4'b0000, "R6 clean commit");
        tick();
        chk("R6 one cycle", {28'd0, commit_mask}, 0);
    endtask

    task automatic t_squash();
        alloc(32'h2040, 4'd2, 6'd9, 2'd0, "R2 alloc");
        inv_valid = 1; inv_addr = 32'h2078;
        tick();
        complete(4'd2, 4'b0000, 4'b0001, "R5 R7 taint by offset in line");
        chk("R7 load tag", {26'd0, res_load_tags[5:0]}, 32'd9);
        complete(4'd2, 4'b0000, 4'b0000, "R9 repeated tag resolves nothing");
    endtask

    task automatic t_same_cycle();
        alloc(32'h3000, 4'd3, 6'd12, 2'd0, "R2 alloc");
        inv_valid = 1; inv_addr = 32'h3004;
        complete(4'd3, 4'b0000, 4'b0001, "R8 inv with completion");
    endtask

    task automatic t_other_line();
        alloc(32'h4000, 4'd4, 6'd7, 2'd0, "R2 alloc");
        inv_valid = 1; inv_addr = 32'h4040;
        tick();
        complete(4'd4, 4'b0001, 4'b0000, "R11 other line ignored");
    endtask

    task automatic t_born_tainted();
        inv_valid = 1; inv_addr = 32'h5010;
        alloc(32'h5000, 4'd9, 6'd33, 2'd0, "R10 alloc");
        complete(4'd9, 4'b0000, 4'b0001, "R10 born tainted");
        chk("R10 tag", {26'd0, res_load_tags[5:0]}, 32'd33);
    endtask

    task automatic t_full();
        put_req(32'h6000, 4'd5, 6'd1, 1'b1, 1'b0, 2'd0, "R3 store refused");
        tick();
        alloc(32'h6000, 4'd5, 6'd1, 2'd0, "R2 slot0");
        alloc(32'h6100, 4'd6, 6'd2, 2'd1, "R2 slot1");
        alloc(32'h6200, 4'd7, 6'd3, 2'd2, "R2 slot2");
        chk("R4 not full at 3", {31'd0, table_full}, 0);
        alloc(32'h6300, 4'd8, 6'd4, 2'd3, "R2 slot3");
        chk("R4 full", {31'd0, table_full}, 1);
        put_req(32'h6400, 4'd8, 6'd10, 1'b0, 1'b0, 2'd0, "R4 refused when full");
        tick();
        inv_valid = 1; inv_addr = 32'h6238;
        tick();
        complete(4'd6, 4'b0010, 4'b0000, "R9 only slot1 resolves");
        chk("R9 not full", {31'd0, table_full}, 0);
        alloc(32'h6500, 4'd10, 6'd11, 2'd1, "R9 slot1 reused");
        complete(4'd5, 4'b0001, 4'b0000, "R9 slot0 untouched");
        complete(4'd7, 4'b0000, 4'b0100, "R5 slot2 tainted");
        chk("R7 slot2 tag", {26'd0, res_load_tags[17:12]}, 32'd3);
        complete(4'd8, 4'b1000, 4'b0000, "R11 slot3 clean");
        complete(4'd10, 4'b0010, 4'b0000, "R6 reused slot");
    endtask

    initial begin
        idle_inputs();
        rst = 1;
        @(negedge clk);
        t_reset();
        tick();
        t_commit();
        t_squash();
        t_same_cycle();
        t_other_line();
        t_born_tainted();
        t_full();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #2000000;
        total++;
        bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule